// File: doc/BRIEF.md
# Indirect Table Access Controller

This block gives a host processor access to a set of wide internal classifier tables through a narrow register window. The host first programs an address register whose top nibble chooses the target table and whose low bits choose a row. It then fills a staging area of seventeen 32-bit words and writes a one-hot command code. The block carries out the access in the background and reports completion by setting, in a status register, the same bit as the command it executed. The host polls that register.

Three packet tables exist, one per parser, placed at table-select values spaced four apart. Three further tables (tree nodes, search entries and result descriptors) are shared by all parsers. A write command copies the staged row into the addressed table row. A read command copies the addressed row back into the staged words, where the host reads it at the same offsets. Search-type commands are accepted and completed but leave every table alone.

Top module: `idxwin_top`

## Requirements
- R1: After reset the status, address and all staged data words read as zero.
- R2: Register offsets are address 0x04, command 0x08 (reads back the last accepted code), status 0x0C, and staged word k at 0x10 + 4*k for k = 0..16; any other offset reads as zero.
- R3: Command codes are write = 0x01, read = 0x02, search-add = 0x08, search-delete = 0x10 and search = 0x20. A command value that is not exactly one of these is ignored: the status keeps its value and no access happens.
- R4: An accepted command clears the status at the edge that accepts it, and the status shows the command's code two clock edges later.
- R5: Address bits 31:28 select the table: 0x0, 0x4 and 0x8 are the packet tables of parsers 0, 1 and 2; 0xC is the node table, 0xD the search table and 0xE the result table. Bits 9:0 hold the row index, and each table has 4 rows.
- R6: A write command stores all 17 staged words into the addressed row, and a read command copies that row back into the 17 staged words.
- R7: The packet tables of different parsers are separate: writing a row of one parser leaves the same row of another parser unchanged.
- R8: A row index of 4 or more, or a select value with no table, still completes with its status bit but changes no table, and a read of it leaves the staged words unchanged.
- R9: Search-add, search-delete and search complete with their status bit and change no table and no staged word.
- R10: From the edge that accepts a command through the edge that sets its status, host writes to any register, including a new command, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWrEn | input | 1 | Register write strobe, captured on the rising edge |
| busAddr | input | 8 | Register byte offset for writes and reads |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busAddr, combinational |

## Verification
The bench first targets row decoding. It writes to row index 5 and to select value 0x1 and then checks that packet row 1 of parser 0 still holds its data. A decoder that truncated the index or ignored unused select values would overwrite that row silently. Another test stores different data in the same row of two parsers, which exposes a stride error that folds the parser tables together. Illegal codes 0x03, 0x04 and 0x41 are issued to catch a controller that accepts multi-bit or undefined commands. The bench also writes a new address and a new command while an access is in flight, to catch a design that lets those writes land mid-operation or clears the status early.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

  localparam int OFF_ADDR = 'h04;
  localparam int OFF_CMD  = 'h08;
  localparam int OFF_STAT = 'h0C;
  localparam int OFF_DATA = 'h10;

  localparam logic [5:0] CMD_WR    = 6'h01;
  localparam logic [5:0] CMD_RD    = 6'h02;
  localparam logic [5:0] CMD_SADD  = 6'h08;
  localparam logic [5:0] CMD_SDEL  = 6'h10;
  localparam logic [5:0] CMD_SRCH  = 6'h20;
  localparam logic [5:0] CMD_LEGAL = CMD_WR | CMD_RD | CMD_SADD | CMD_SDEL | CMD_SRCH;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_FINISH} ctrlState_t;

  typedef struct packed {
    logic       clrStatus;
    logic       memWr;
    logic       memRd;
    logic       setDone;
    logic [5:0] doneCode;
    logic       lock;
  } ctrlStrobe_t;

endpackage

// File: rtl/idxwin_ctrl.sv
module idxwin_ctrl
  import idxwin_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdWrite,
  input  logic [31:0] cmdData,
  output logic [5:0]  cmdCode,
  output ctrlStrobe_t strb
);

  ctrlState_t state;
  logic [5:0] cmdQ;
  logic       cmdOk;

  assign cmdOk = (cmdData[31:6] == '0) && ((cmdData[5:0] & ~CMD_LEGAL) == '0)
                 && $onehot(cmdData[5:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cmdQ  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (cmdWrite && cmdOk) begin
          cmdQ  <= cmdData[5:0];
          state <= ST_ACCESS;
        end
        ST_ACCESS: state <= ST_FINISH;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.clrStatus = (state == ST_IDLE) && cmdWrite && cmdOk;
    strb.memWr     = (state == ST_ACCESS) && (cmdQ == CMD_WR);
    strb.memRd     = (state == ST_ACCESS) && (cmdQ == CMD_RD);
    strb.setDone   = (state == ST_FINISH);
    strb.doneCode  = cmdQ;
    strb.lock      = (state != ST_IDLE);
  end

  assign cmdCode = cmdQ;

  assert_finish_follows_access_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINISH) |-> $past(state == ST_ACCESS));

  assert_cmd_held_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(cmdQ));

endmodule

// File: rtl/idxwin_datapath.sv
module idxwin_datapath
  import idxwin_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WORDS   = 17,
  parameter int ROWS    = 4,
  parameter int IDX_W   = 10,
  parameter int NPARSER = 3,
  parameter int PSTRIDE = 4,
  parameter int SHARED_BASE = 12,
  parameter int NSHARED = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWrData,
  input  logic [5:0]        cmdCode,
  input  ctrlStrobe_t       strb,
  output logic [31:0]       hostRdData
);

  localparam int NBANK = NPARSER + NSHARED;
  localparam int ROWB  = WORDS * 32;
  localparam int RB    = $clog2(ROWS);
  localparam int WB    = $clog2(WORDS);
  localparam logic [ADDR_W-1:0] A_ADDR  = ADDR_W'(OFF_ADDR);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_DEND  = ADDR_W'(OFF_DATA + 4 * WORDS);

  logic [31:0]             addrReg;
  logic [WORDS-1:0][31:0]  stage;
  logic [5:0]              statusQ;
  logic [NBANK-1:0]        hit;
  logic [NBANK:0][ROWB-1:0] orChain;
  logic [3:0]              tblSel;
  logic [RB-1:0]           rowIdx;
  logic                    rowOk;
  logic                    isData;
  logic [ADDR_W-1:0]       dataOff;
  logic [WB-1:0]           wordIdx;

  assign tblSel  = addrReg[31:28];
  assign rowIdx  = addrReg[RB-1:0];
  assign rowOk   = addrReg[IDX_W-1:0] < IDX_W'(ROWS);
  assign isData  = (hostAddr >= A_DATA) && (hostAddr < A_DEND) && (hostAddr[1:0] == 2'b00);
  assign dataOff = (hostAddr - A_DATA) >> 2;
  assign wordIdx = dataOff[WB-1:0];
  assign orChain[0] = '0;

  for (genvar b = 0; b < NBANK; b++) begin : gBank
    localparam logic [3:0] BSEL = (b < NPARSER) ? 4'(b * PSTRIDE) : 4'(SHARED_BASE + b - NPARSER);
    logic [ROWB-1:0] mem [ROWS];

    assign hit[b] = (tblSel == BSEL) && rowOk;

    always_ff @(posedge clk) begin
      if (strb.memWr && hit[b]) mem[rowIdx] <= stage;
    end

    assign orChain[b+1] = orChain[b] | (hit[b] ? mem[rowIdx] : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg <= '0;
      stage   <= '0;
      statusQ <= '0;
    end else begin
      if (hostWr && !strb.lock) begin
        if (hostAddr == A_ADDR) addrReg <= hostWrData;
        if (isData) stage[wordIdx] <= hostWrData;
      end
      if (strb.memRd && (|hit)) stage <= orChain[NBANK];
      if (strb.clrStatus) statusQ <= '0;
      else if (strb.setDone) statusQ <= strb.doneCode;
    end
  end

  always_comb begin
    hostRdData = '0;
    if (hostAddr == A_ADDR)      hostRdData = addrReg;
    else if (hostAddr == A_CMD)  hostRdData = {26'b0, cmdCode};
    else if (hostAddr == A_STAT) hostRdData = {26'b0, statusQ};
    else if (isData)             hostRdData = stage[wordIdx];
  end

  assert_status_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(statusQ));

  assert_status_set_in_op_R4: assert property (@(posedge clk) disable iff (rst)
    ((statusQ != '0) && ($past(statusQ) == '0)) |-> $past(strb.lock));

  assert_addr_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    strb.lock |=> $stable(addrReg));

endmodule

// File: rtl/idxwin_top.sv
module idxwin_top
  import idxwin_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WORDS   = 17,
  parameter int ROWS    = 4,
  parameter int IDX_W   = 10,
  parameter int NPARSER = 3
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData
);

  ctrlStrobe_t strb;
  logic [5:0]  cmdCode;
  logic        cmdWrite;

  assign cmdWrite = busWrEn && (busAddr == ADDR_W'(OFF_CMD));

  idxwin_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .cmdWrite (cmdWrite),
    .cmdData  (busWrData),
    .cmdCode  (cmdCode),
    .strb     (strb)
  );

  idxwin_datapath #(
    .ADDR_W  (ADDR_W),
    .WORDS   (WORDS),
    .ROWS    (ROWS),
    .IDX_W   (IDX_W),
    .NPARSER (NPARSER)
  ) uData (
    .clk        (clk),
    .rst        (rst),
    .hostWr     (busWrEn),
    .hostAddr   (busAddr),
    .hostWrData (busWrData),
    .cmdCode    (cmdCode),
    .strb       (strb),
    .hostRdData (busRdData)
  );

endmodule

// File: tb/tb_idxwin_top.sv
module tb_idxwin_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWrEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       tag;
  } expItem_t;

  expItem_t sbq[$];

  always #5 clk = ~clk;

  idxwin_top dut (
    .clk       (clk),
    .rst       (rst),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData)
  );

  // monitor: compares the pending expectation in the middle of the cycle
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      expItem_t it;
      it = sbq.pop_front();
      tests++;
      if (busRdData !== it.e) begin
        fails++;
        $display("FAIL %s offset 0x%02h: got 0x%08h expected 0x%08h", it.tag, it.a, busRdData, it.e);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
  endtask

  task automatic expectRd(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    busAddr = a;
    it.a = a; it.e = e; it.tag = tag;
    sbq.push_back(it);
    tick();
  endtask

  task automatic loadStage(input logic [31:0] base);
    for (int k = 0; k < 17; k++) busWrite(8'(8'h10 + 4 * k), base + k);
  endtask

  task automatic expectStage(input logic [31:0] base, input string tag);
    for (int k = 0; k < 17; k++) expectRd(8'(8'h10 + 4 * k), base + k, tag);
  endtask

  task automatic runCmd(input logic [31:0] code);
    busWrite(8'h08, code);
    tick();
    tick();
  endtask

  task automatic readRow(input logic [31:0] addr);
    busWrite(8'h04, addr);
    runCmd(32'h2);
  endtask

  task automatic writeRow(input logic [31:0] addr, input logic [31:0] base);
    busWrite(8'h04, addr);
    loadStage(base);
    runCmd(32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    expectRd(8'h0C, 32'h0, "R1 status");
    expectRd(8'h04, 32'h0, "R1 address");
    expectRd(8'h10, 32'h0, "R1 word0");
    expectRd(8'h50, 32'h0, "R1 word16");

    // R2 register map
    busWrite(8'h04, 32'h0000_0001);
    expectRd(8'h04, 32'h0000_0001, "R2 address readback");
    busWrite(8'h30, 32'h1234_5678);
    expectRd(8'h30, 32'h1234_5678, "R2 word8 readback");
    expectRd(8'h54, 32'h0, "R2 unmapped 0x54");
    expectRd(8'h00, 32'h0, "R2 unmapped 0x00");

    // R4 timing and R6 write, parser 0 row 1
    loadStage(32'hA000_0000);
    busWrite(8'h08, 32'h1);
    expectRd(8'h0C, 32'h0, "R4 status clear after accept");
    expectRd(8'h0C, 32'h0, "R4 status not yet set");
    expectRd(8'h0C, 32'h1, "R4 status write done");
    expectRd(8'h08, 32'h1, "R2 command readback");

    // R6 read back
    loadStage(32'h5555_0000);
    readRow(32'h0000_0001);
    expectRd(8'h0C, 32'h2, "R6 read status");
    expectStage(32'hA000_0000, "R6 read row");

    // R7 parser separation
    writeRow(32'h4000_0001, 32'hB000_0000);
    readRow(32'h0000_0001);
    expectStage(32'hA000_0000, "R7 parser0 intact");
    readRow(32'h4000_0001);
    expectStage(32'hB000_0000, "R7 parser1 row");

    // R5 table selects
    writeRow(32'h8000_0000, 32'h8800_0000);
    writeRow(32'hC000_0002, 32'hC000_0000);
    writeRow(32'hD000_0000, 32'hD000_0000);
    writeRow(32'hE000_0003, 32'hE000_0000);
    readRow(32'h8000_0000);
    expectStage(32'h8800_0000, "R5 parser2 table");
    readRow(32'hC000_0002);
    expectStage(32'hC000_0000, "R5 node table");
    readRow(32'hD000_0000);
    expectStage(32'hD000_0000, "R5 search table");
    readRow(32'hE000_0003);
    expectStage(32'hE000_0000, "R5 result table");

    // R8 out-of-range row and unimplemented select
    writeRow(32'h0000_0005, 32'h1D00_0000);
    expectRd(8'h0C, 32'h1, "R8 out-of-range completes");
    writeRow(32'h1000_0001, 32'h1E00_0000);
    expectRd(8'h0C, 32'h1, "R8 bad select completes");
    readRow(32'h0000_0001);
    expectStage(32'hA000_0000, "R8 parser0 row1 intact");
    loadStage(32'h7700_0000);
    readRow(32'h0000_0005);
    expectRd(8'h0C, 32'h2, "R8 out-of-range read completes");
    expectStage(32'h7700_0000, "R8 stage unchanged");

    // R9 search commands
    busWrite(8'h04, 32'h0000_0001);
    loadStage(32'hF000_0000);
    runCmd(32'h20);
    expectRd(8'h0C, 32'h20, "R9 search status");
    expectStage(32'hF000_0000, "R9 stage kept");
    runCmd(32'h08);
    expectRd(8'h0C, 32'h08, "R9 search-add status");
    runCmd(32'h10);
    expectRd(8'h0C, 32'h10, "R9 search-delete status");
    readRow(32'h0000_0001);
    expectStage(32'hA000_0000, "R9 table unchanged");

    // R3 illegal codes ignored (status stays 0x02)
    runCmd(32'h3);
    expectRd(8'h0C, 32'h2, "R3 code 0x03 ignored");
    runCmd(32'h4);
    expectRd(8'h0C, 32'h2, "R3 code 0x04 ignored");
    runCmd(32'h41);
    expectRd(8'h0C, 32'h2, "R3 code 0x41 ignored");
    loadStage(32'h6600_0000);
    runCmd(32'h0);
    expectStage(32'h6600_0000, "R3 code 0x00 no access");

    // R10 writes during an operation
    busWrite(8'h04, 32'hC000_0001);
    busWrite(8'h08, 32'h1);
    busWrite(8'h04, 32'h4000_0000);
    busWrite(8'h08, 32'h2);
    expectRd(8'h0C, 32'h1, "R10 second command ignored");
    expectRd(8'h04, 32'hC000_0001, "R10 address write ignored");
    readRow(32'hC000_0001);
    expectStage(32'h6600_0000, "R10 write landed on original row");

    tick();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule